// File: doc/BRIEF.md
# Board Watchdog and Control Register Block

This block sits on a byte-wide, ISA-style I/O port and answers a window of four consecutive addresses starting at a parameterised base. The default base is 0x200. Inside the window there are three registers. The first is a read-only status byte. The second is a watchdog port that accepts only two magic byte values. The third is a write-only control byte. Writes and reads outside the window have no effect.

The watchdog starts disarmed. It is armed by one magic write, and after that only a reset can disarm it. Once armed, it counts timer ticks (a clock-enable input) and expects a keepalive write before a parameterised number of ticks has passed. When the keepalive is missed, the watchdog line goes low. A static two-bit strap input then decides what the timeout does: a one-cycle NMI pulse, a reset request held for a parameterised number of cycles, or nothing. The control byte gates two things: the flash-disk access enable and the forwarding of the processor thermal alarm to an interrupt output.

Top module: `brd_wdog_regs`

## Requirements
- R1: After reset the watchdog is disarmed, `wdog_n` is 1, `nmi_pulse` and `hrst_req` are 0, `flash_en` equals the RST_FLASH parameter, and thermal forwarding equals the RST_THERM parameter.
- R2: Only addresses whose bits above bit 1 match BASE are decoded. Bits [1:0] select the register: 0 is status, 1 is the watchdog port, 2 is control, 3 is spare. A read outside the window returns 0x00. A write outside the window changes nothing.
- R3: A write of 0x55 to offset 1 arms the watchdog. Any other value written to offset 1 while disarmed, 0x7F included, is ignored. While disarmed, `wdog_n` stays 1.
- R4: Once armed, the watchdog stays armed until reset. Values other than 0x55 and 0x7F written to offset 1 neither disarm it nor restart its count.
- R5: While armed, a write of 0x7F or 0x55 to offset 1 clears the tick count and returns `wdog_n` to 1. The count advances only in cycles where `tick_en` is 1.
- R6: If the watchdog is armed and PERIOD_TICKS ticks pass with no retrigger, `wdog_n` goes low on the clock edge of the last tick. It stays low until the next retrigger. The count then reloads and runs again.
- R7: With strap 2'b01, every timeout raises `nmi_pulse` for exactly one cycle, in the same cycle that the timeout drives `wdog_n` low.
- R8: With strap 2'b10, every timeout raises `hrst_req` one cycle after the timeout and holds it for RST_CYCLES cycles.
- R9: With strap 2'b00 or 2'b11, a timeout drives `wdog_n` low but raises neither `nmi_pulse` nor `hrst_req`.
- R10: The status byte at offset 0 is laid out as follows. Bit 0 is 1 when armed. Bit 4 copies `therm_n`, so it reads 0 during overtemperature. Bit 5 is the flash-access enable. All other bits read 0.
- R11: A write to offset 2 sets `flash_en` from data bit 0 and thermal forwarding from data bit 4. Reads of offsets 1, 2 and 3 return 0xFF.
- R12: `therm_irq` is 1 exactly when thermal forwarding is enabled and `therm_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timeout time base, one tick per cycle it is high |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| strap_mode | input | 2 | Timeout action strap: 01 NMI, 10 reset, 00/11 none |
| therm_n | input | 1 | CPU overtemperature, active low |
| wdog_n | output | 1 | Watchdog state, low after a missed keepalive |
| nmi_pulse | output | 1 | One-cycle NMI request per timeout |
| hrst_req | output | 1 | Held hardware reset request |
| therm_irq | output | 1 | Forwarded thermal interrupt |
| flash_en | output | 1 | Flash-disk access enable |

## Verification
The bench builds the block with PERIOD_TICKS = 8 and RST_CYCLES = 3, with `tick_en` held high for most of the run. A timeout therefore lands a fixed, small number of cycles after the last retrigger. Because of this, the bench can check the cycle before and the cycle of each NMI pulse, the repeat of the pulse after the reload, and both edges of the held reset request. The short period also makes it cheap to show several cases: that 0x00 does not postpone the timeout while 0x55 does, that a long stretch with `tick_en` low never expires, and the behaviour under all four strap values, each after a fresh reset.

// File: rtl/brd_wdog_pkg.sv
package brd_wdog_pkg;

   typedef enum logic [1:0] {
      WD_ACT_NONE  = 2'b00,
      WD_ACT_NMI   = 2'b01,
      WD_ACT_RST   = 2'b10,
      WD_ACT_SPARE = 2'b11
   } wd_act_e;

   localparam logic [1:0] OFS_STAT  = 2'd0;
   localparam logic [1:0] OFS_WDOG  = 2'd1;
   localparam logic [1:0] OFS_CTRL  = 2'd2;

   localparam logic [7:0] MAGIC_ARM  = 8'h55;
   localparam logic [7:0] MAGIC_KICK = 8'h7F;

   localparam int SBIT_ARMED    = 0;
   localparam int SBIT_THERM_OK = 4;
   localparam int SBIT_FLASH    = 5;

   localparam int CBIT_FLASH = 0;
   localparam int CBIT_THERM = 4;

   localparam logic [7:0] RD_NOREG = 8'hFF;
   localparam logic [7:0] RD_IDLE  = 8'h00;

endpackage

// File: rtl/brd_wdog_decode.sv
module brd_wdog_decode
   import brd_wdog_pkg::*;
#(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h0200
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        stat_byte,
   output logic              wr_wdog,
   output logic              wr_ctrl,
   output logic [7:0]        io_rdata
);

   localparam int               TAG_W   = ADDR_W - 2;
   localparam logic [TAG_W-1:0] WIN_TAG = BASE[ADDR_W-1:2];

   logic       in_win;
   logic [1:0] ofs;

   assign in_win  = (io_addr[ADDR_W-1:2] == WIN_TAG);
   assign ofs     = io_addr[1:0];
   assign wr_wdog = io_wr && in_win && (ofs == OFS_WDOG);
   assign wr_ctrl = io_wr && in_win && (ofs == OFS_CTRL);

   always_comb begin
      io_rdata = RD_IDLE;
      if (io_rd && in_win) begin
         if (ofs == OFS_STAT) io_rdata = stat_byte;
         else                 io_rdata = RD_NOREG;
      end
   end

endmodule

// File: rtl/brd_wdog_ctrl.sv
module brd_wdog_ctrl #(
   parameter bit RST_FLASH = 1'b1,
   parameter bit RST_THERM = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic d_flash,
   input  logic d_therm,
   input  logic therm_n,
   output logic flash_en,
   output logic therm_fwd,
   output logic therm_irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flash_en  <= RST_FLASH;
         therm_fwd <= RST_THERM;
      end else if (wr_ctrl) begin
         flash_en  <= d_flash;
         therm_fwd <= d_therm;
      end
   end

   assign therm_irq = therm_fwd && !therm_n;

endmodule

// File: rtl/brd_wdog_timer.sv
module brd_wdog_timer
   import brd_wdog_pkg::*;
#(
   parameter int PERIOD_TICKS = 1200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       wr_wdog,
   input  logic [7:0] wdata,
   output logic       armed,
   output logic       timed_out,
   output logic       expire_evt
);

   localparam int              CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

   logic [CNT_W-1:0] cnt;
   logic             arm_hit;
   logic             kick_hit;
   logic             restart;
   logic             step;

   assign arm_hit  = wr_wdog && (wdata == MAGIC_ARM);
   assign kick_hit = wr_wdog && armed && (wdata == MAGIC_KICK);
   assign restart  = arm_hit || kick_hit;
   assign step     = armed && tick_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         cnt        <= '0;
         timed_out  <= 1'b0;
         expire_evt <= 1'b0;
      end else begin
         armed <= armed || arm_hit;
         if (restart) begin
            cnt        <= '0;
            timed_out  <= 1'b0;
            expire_evt <= 1'b0;
         end else if (step && (cnt == LAST)) begin
            cnt        <= '0;
            timed_out  <= 1'b1;
            expire_evt <= 1'b1;
         end else begin
            if (step) cnt <= cnt + CNT_W'(1);
            expire_evt <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/brd_wdog_action.sv
module brd_wdog_action
   import brd_wdog_pkg::*;
#(
   parameter int RST_CYCLES = 16
) (
   input  logic    clk,
   input  logic    rst_n,
   input  wd_act_e mode,
   input  logic    expire_evt,
   output logic    nmi_pulse,
   output logic    hrst_req
);

   logic fire_rst;

   assign nmi_pulse = expire_evt && (mode == WD_ACT_NMI);
   assign fire_rst  = expire_evt && (mode == WD_ACT_RST);

   generate
      if (RST_CYCLES == 1) begin : g_hold_flop
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= fire_rst;
         end
         assign hrst_req = hold_q;
      end else begin : g_hold_cnt
         localparam int               HOLD_W   = $clog2(RST_CYCLES + 1);
         localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(RST_CYCLES);
         logic [HOLD_W-1:0] hold_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hold_cnt <= '0;
            else if (fire_rst)         hold_cnt <= HOLD_LD;
            else if (hold_cnt != '0)   hold_cnt <= hold_cnt - HOLD_W'(1);
         end
         assign hrst_req = (hold_cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/brd_wdog_regs.sv
module brd_wdog_regs
   import brd_wdog_pkg::*;
#(
   parameter int                ADDR_W       = 16,
   parameter logic [ADDR_W-1:0] BASE         = 16'h0200,
   parameter int                PERIOD_TICKS = 1200,
   parameter int                RST_CYCLES   = 16,
   parameter bit                RST_FLASH    = 1'b1,
   parameter bit                RST_THERM    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [1:0]        strap_mode,
   input  logic              therm_n,
   output logic              wdog_n,
   output logic              nmi_pulse,
   output logic              hrst_req,
   output logic              therm_irq,
   output logic              flash_en
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (BASE[1:0] != 2'b00) begin : g_bad_base
         $error("BASE must be aligned to a four-byte window");
      end
      if (PERIOD_TICKS < 2) begin : g_bad_period
         $error("PERIOD_TICKS must be at least 2");
      end
      if (RST_CYCLES < 1) begin : g_bad_hold
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic       wr_wdog;
   logic       wr_ctrl;
   logic       wd_armed;
   logic       timed_out;
   logic       expire_evt;
   logic       therm_fwd;
   logic [7:0] stat_byte;
   wd_act_e    mode;

   assign mode   = wd_act_e'(strap_mode);
   assign wdog_n = !timed_out;

   always_comb begin
      stat_byte                = '0;
      stat_byte[SBIT_ARMED]    = wd_armed;
      stat_byte[SBIT_THERM_OK] = therm_n;
      stat_byte[SBIT_FLASH]    = flash_en;
   end

   brd_wdog_decode #(
      .ADDR_W (ADDR_W),
      .BASE   (BASE)
   ) u_dec (
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_rd     (io_rd),
      .stat_byte (stat_byte),
      .wr_wdog   (wr_wdog),
      .wr_ctrl   (wr_ctrl),
      .io_rdata  (io_rdata)
   );

   brd_wdog_ctrl #(
      .RST_FLASH (RST_FLASH),
      .RST_THERM (RST_THERM)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .d_flash   (io_wdata[CBIT_FLASH]),
      .d_therm   (io_wdata[CBIT_THERM]),
      .therm_n   (therm_n),
      .flash_en  (flash_en),
      .therm_fwd (therm_fwd),
      .therm_irq (therm_irq)
   );

   brd_wdog_timer #(
      .PERIOD_TICKS (PERIOD_TICKS)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .wr_wdog    (wr_wdog),
      .wdata      (io_wdata),
      .armed      (wd_armed),
      .timed_out  (timed_out),
      .expire_evt (expire_evt)
   );

   brd_wdog_action #(
      .RST_CYCLES (RST_CYCLES)
   ) u_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .expire_evt (expire_evt),
      .nmi_pulse  (nmi_pulse),
      .hrst_req   (hrst_req)
   );

endmodule

// File: rtl/brd_wdog_chk.sv
module brd_wdog_chk #(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h0200
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        strap_mode,
   input logic              therm_n,
   input logic              therm_irq,
   input logic              nmi_pulse,
   input logic              hrst_req,
   input logic              wdog_n,
   input logic              wd_armed,
   input logic              io_rd,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_rdata
);

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |=> !nmi_pulse);                                        // R7
   AST_NMI_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |-> (strap_mode == 2'b01));                             // R7
   AST_RST_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hrst_req) |-> (strap_mode == 2'b10));                       // R8
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_mode == 2'b00 || strap_mode == 2'b11) |-> (!nmi_pulse && !hrst_req)); // R9
   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wd_armed |=> wd_armed);                                           // R4
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_armed |-> wdog_n);                                            // R3
   AST_NMI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pulse |-> !wdog_n);                                           // R6
   AST_THERM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      therm_irq |-> !therm_n);                                          // R12
   AST_OUT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && (io_addr[ADDR_W-1:2] != BASE[ADDR_W-1:2])) |-> (io_rdata == 8'h00)); // R2

endmodule

bind brd_wdog_regs brd_wdog_chk #(
   .ADDR_W (ADDR_W),
   .BASE   (BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strap_mode (strap_mode),
   .therm_n    (therm_n),
   .therm_irq  (therm_irq),
   .nmi_pulse  (nmi_pulse),
   .hrst_req   (hrst_req),
   .wdog_n     (wdog_n),
   .wd_armed   (wd_armed),
   .io_rd      (io_rd),
   .io_addr    (io_addr),
   .io_rdata   (io_rdata)
);

// File: tb/sim_brd_wdog_regs.sv
`timescale 1ns/1ps
module sim_brd_wdog_regs;

   localparam int ADDR_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b1;
   logic [ADDR_W-1:0] io_addr = '0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic [7:0]        io_wdata = '0;
   logic [7:0]        io_rdata;
   logic [1:0]        strap_mode = 2'b01;
   logic              therm_n = 1'b1;
   logic              wdog_n;
   logic              nmi_pulse;
   logic              hrst_req;
   logic              therm_irq;
   logic              flash_en;

   always #2.5 clk = !clk;

   brd_wdog_regs #(
      .ADDR_W       (ADDR_W),
      .BASE         (16'h0200),
      .PERIOD_TICKS (8),
      .RST_CYCLES   (3),
      .RST_FLASH    (1'b1),
      .RST_THERM    (1'b0)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .io_addr    (io_addr),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .strap_mode (strap_mode),
      .therm_n    (therm_n),
      .wdog_n     (wdog_n),
      .nmi_pulse  (nmi_pulse),
      .hrst_req   (hrst_req),
      .therm_irq  (therm_irq),
      .flash_en   (flash_en)
   );

   // scoreboard item: sel 0 compares io_rdata, sel 1 compares the output vector
   // {3'b0, nmi_pulse, hrst_req, wdog_n, therm_irq, flash_en}
   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;
   item_t it;
   logic [7:0] got;

   always @(negedge clk) begin
      if (sb.size() > 0) begin
         it  = sb.pop_front();
         got = (it.sel == 0) ? io_rdata
                             : {3'b000, nmi_pulse, hrst_req, wdog_n, therm_irq, flash_en};
         n_chk++;
         if (got !== it.exp) begin
            n_err++;
            $display("FAIL %s %s got=%h exp=%h", it.req,
                     (it.sel == 0) ? "rdata" : "outputs", got, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      cyc();
      io_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string r);
      io_addr = a; io_rd = 1'b1;
      sb.push_back('{0, e, r});
      cyc();
      io_rd = 1'b0;
   endtask

   task automatic out_chk(input logic [7:0] e, input string r);
      sb.push_back('{1, e, r});
      cyc();
   endtask

   task automatic do_reset(input logic [1:0] m);
      rst_n = 1'b0; strap_mode = m; tick_en = 1'b1; therm_n = 1'b1;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired got=hung exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset(2'b01);
      // R1 reset state
      out_chk(8'h05, "R1");
      rd_chk(16'h0200, 8'h30, "R1");
      // R11 write-only and spare offsets read all ones
      rd_chk(16'h0201, 8'hFF, "R11");
      rd_chk(16'h0202, 8'hFF, "R11");
      rd_chk(16'h0203, 8'hFF, "R11");
      // R2 outside the window
      rd_chk(16'h0600, 8'h00, "R2");
      wr(16'h0601, 8'h55);
      wr(16'h0602, 8'h00);
      rd_chk(16'h0200, 8'h30, "R2");
      out_chk(8'h05, "R2");
      // R3 wrong values while disarmed
      wr(16'h0201, 8'h7F);
      wr(16'h0201, 8'h54);
      rd_chk(16'h0200, 8'h30, "R3");
      repeat (10) cyc();
      out_chk(8'h05, "R3");
      // R11 / R10 / R12 control and status
      wr(16'h0202, 8'h10);
      out_chk(8'h04, "R11");
      rd_chk(16'h0200, 8'h10, "R10");
      therm_n = 1'b0;
      out_chk(8'h06, "R12");
      rd_chk(16'h0200, 8'h00, "R10");
      wr(16'h0202, 8'h01);
      out_chk(8'h05, "R12");
      rd_chk(16'h0200, 8'h20, "R10");
      therm_n = 1'b1;
      // arm and time out in NMI mode
      wr(16'h0201, 8'h55);               // edge E0
      rd_chk(16'h0200, 8'h31, "R3");      // now after E1
      repeat (6) cyc();
      out_chk(8'h05, "R6");               // after E7: not yet
      out_chk(8'h11, "R7");               // after E8: pulse, wdog low
      out_chk(8'h01, "R7");               // after E9: pulse gone
      repeat (5) cyc();
      out_chk(8'h01, "R6");               // after E15
      out_chk(8'h11, "R7");               // after E16: second pulse
      // R5 retrigger keeps it alive
      wr(16'h0201, 8'h7F);
      out_chk(8'h05, "R5");
      for (int k = 0; k < 3; k++) begin
         repeat (3) cyc();
         wr(16'h0201, 8'h7F);
      end
      repeat (6) cyc();
      out_chk(8'h05, "R5");
      // R4 other value neither disarms nor restarts
      wr(16'h0201, 8'h7F);                // K0
      cyc(); cyc();
      wr(16'h0201, 8'h00);                // K3
      repeat (4) cyc();
      out_chk(8'h05, "R4");               // after K7
      out_chk(8'h11, "R4");               // after K8
      rd_chk(16'h0200, 8'h31, "R4");
      // R5 repeated arm byte restarts
      wr(16'h0201, 8'h7F);                // L0
      cyc(); cyc();
      wr(16'h0201, 8'h55);                // L3
      repeat (7) cyc();
      out_chk(8'h05, "R5");               // after L10
      out_chk(8'h11, "R5");               // after L11
      // R5 no ticks, no timeout
      wr(16'h0201, 8'h7F);
      tick_en = 1'b0;
      repeat (20) cyc();
      out_chk(8'h05, "R5");
      tick_en = 1'b1;
      // R4 reset disarms
      do_reset(2'b01);
      rd_chk(16'h0200, 8'h30, "R4");
      // R8 reset mode
      do_reset(2'b10);
      wr(16'h0201, 8'h55);                // E0
      repeat (7) cyc();
      out_chk(8'h05, "R8");               // after E7
      out_chk(8'h01, "R8");               // after E8
      out_chk(8'h09, "R8");               // after E9
      out_chk(8'h09, "R8");
      out_chk(8'h09, "R8");
      out_chk(8'h01, "R8");               // after E12
      // R9 both inactive strap codes
      for (int m = 0; m < 2; m++) begin
         do_reset(m == 0 ? 2'b00 : 2'b11);
         wr(16'h0201, 8'h55);
         repeat (7) cyc();
         out_chk(8'h05, "R9");
         out_chk(8'h01, "R9");
         out_chk(8'h01, "R9");
      end
      cyc(); cyc();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule